// File: doc/BRIEF.md
# Row-by-Row Precharged Readout Sequencer

This block drives the readout of a pixel array whose cells each hold a small digital word. Rows are read one at a time. For each row the sequencer first charges the column buses high while the row access switches stay open. It then releases the complementary bus to high impedance and only afterwards closes the access switches of the addressed row. Once the sense path reports ready, it latches the whole row, 64 words of 4 bits by default. The latched row is then sent out one column word per cycle on a narrow data output, marked by a valid strobe.

Each of the three analog phases (precharge, release, access) lasts a number of cycles set by an input. A value of zero counts as one cycle. The row address moves on only after the last word of the current row has left the block. After the final row a one-cycle done pulse is given and the sequencer goes back to idle. The analog sensing itself, the bus capacitance and the pixel cells lie outside the block. The array presents the addressed row on `row_data`.

Top module: `row_readout_seq`

## Requirements
- R1: After synchronous reset, and whenever idle, `precharge`, `bus_hiz`, `access_en`, `latch_en`, `dvalid` and `done` are all low and `row_sel` is 0.
- R2: A `start` seen in idle begins a frame at row 0 with the precharge phase in the next cycle. A `start` seen while a frame is running has no effect.
- R3: The precharge phase holds `precharge` high, with `bus_hiz` and `access_en` low, for exactly `pre_len` cycles (0 counts as 1). It is always the first phase of every row.
- R4: The release phase follows precharge directly. It holds `bus_hiz` high with `precharge` and `access_en` low for exactly `hiz_len` cycles (0 counts as 1).
- R5: The access phase follows the release phase. It holds `bus_hiz` and `access_en` high and lasts until the first cycle, counted from 1, that is at least `acc_len` (0 counts as 1) and in which `sense_ready` is high.
- R6: After access, `latch_en` is high for exactly one cycle, with `access_en` and `bus_hiz` still high. In that cycle the row on `row_data` is captured. Changes on `row_data` at any other time have no effect on the words sent out.
- R7: After the latch cycle, `dvalid` is high for COLS consecutive cycles with all bus strobes low. In cycle c (0-based) `dout` carries column c, which is `row_data[c*4 +: 4]` as captured, so columns leave in ascending order.
- R8: `row_sel` stays constant while a row is processed. It rises by one only in the cycle after the row's last output word, and that row then starts again with precharge.
- R9: After the last word of row ROWS-1, `done` is high for exactly one cycle, then the block is idle with `row_sel` back at 0. `precharge` is never high together with `bus_hiz` or `access_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| pre_len | input | LEN_W | Precharge phase length in cycles (0 means 1) |
| hiz_len | input | LEN_W | Bus release phase length in cycles (0 means 1) |
| acc_len | input | LEN_W | Minimum access phase length in cycles (0 means 1) |
| sense_ready | input | 1 | Sense path has settled on the accessed row |
| row_data | input | COLS*WORD_W | Words of the addressed row, column c at bits c*WORD_W upward |
| precharge | output | 1 | Charge column buses high |
| bus_hiz | output | 1 | Complementary bus released to high impedance |
| access_en | output | 1 | Row access switches closed |
| latch_en | output | 1 | Capture strobe for the sensed row |
| row_sel | output | clog2(ROWS) | Address of the row being read |
| dout | output | WORD_W | Column word being output |
| dvalid | output | 1 | `dout` holds a valid word |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
The bench builds the block with ROWS=4, COLS=6 and LEN_W=3. A frame is then short enough that many complete frames fit in one run, so the step from the last row to the done pulse and back to idle is taken many times. A three-bit length field reaches both ends of its range: zero, which must count as one cycle, and the maximum of seven. A column count that is not a power of two checks that the column counter wraps at COLS-1 and not at the counter's width.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HIZ,
        ST_ACC,
        ST_LAT,
        ST_OUT,
        ST_DONE
    } rr_state_e;

    typedef struct packed {
        logic precharge;
        logic bus_hiz;
        logic access_en;
        logic latch_en;
        logic dvalid;
        logic done;
    } rr_ctrl_t;

    function automatic rr_ctrl_t ctrl_of(rr_state_e s);
        rr_ctrl_t c;
        c = '0;
        case (s)
            ST_PRE:  c.precharge = 1'b1;
            ST_HIZ:  c.bus_hiz   = 1'b1;
            ST_ACC: begin
                c.bus_hiz   = 1'b1;
                c.access_en = 1'b1;
            end
            ST_LAT: begin
                c.bus_hiz   = 1'b1;
                c.access_en = 1'b1;
                c.latch_en  = 1'b1;
            end
            ST_OUT:  c.dvalid = 1'b1;
            ST_DONE: c.done   = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rr_phase_timer.sv
module rr_phase_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             expired
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? '0 : len - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rr_row_buffer.sv
module rr_row_buffer #(
    parameter int COLS   = 64,
    parameter int WORD_W = 4,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic [COLS*WORD_W-1:0] row_in,
    input  logic [COL_W-1:0]       col_idx,
    output logic [WORD_W-1:0]      word_out
);
    logic [WORD_W-1:0] words [COLS];

    for (genvar g = 0; g < COLS; g++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (capture) begin
                words[g] <= row_in[g*WORD_W +: WORD_W];
            end
        end
    end

    assign word_out = words[col_idx];
endmodule

// File: rtl/rr_fsm.sv
module rr_fsm
    import rr_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int COLS  = 64,
    parameter int LEN_W = 4,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sense_ready,
    input  logic [LEN_W-1:0] pre_len,
    input  logic [LEN_W-1:0] hiz_len,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [LEN_W-1:0] tmr_len,
    output rr_state_e        state,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    rr_state_e state_n;
    logic      col_end;
    logic      row_end;

    assign col_end = (col == COL_LAST);
    assign row_end = (row == ROW_LAST);

    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_len  = pre_len;
        case (state)
            ST_IDLE: if (start) begin
                state_n  = ST_PRE;
                tmr_load = 1'b1;
            end
            ST_PRE: if (tmr_expired) begin
                state_n  = ST_HIZ;
                tmr_load = 1'b1;
                tmr_len  = hiz_len;
            end
            ST_HIZ: if (tmr_expired) begin
                state_n  = ST_ACC;
                tmr_load = 1'b1;
                tmr_len  = '0;
            end
            ST_ACC: if (tmr_expired && sense_ready) begin
                state_n = ST_LAT;
            end
            ST_LAT: state_n = ST_OUT;
            ST_OUT: if (col_end) begin
                if (row_end) begin
                    state_n = ST_DONE;
                end else begin
                    state_n  = ST_PRE;
                    tmr_load = 1'b1;
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
        end else begin
            state <= state_n;
            if (state == ST_OUT && !col_end) begin
                col <= col + 1'b1;
            end else begin
                col <= '0;
            end
            if (state == ST_DONE) begin
                row <= '0;
            end else if (state == ST_OUT && col_end && !row_end) begin
                row <= row + 1'b1;
            end
        end
    end
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq
    import rr_pkg::*;
#(
    parameter int ROWS   = 64,
    parameter int COLS   = 64,
    parameter int WORD_W = 4,
    parameter int LEN_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [LEN_W-1:0]         pre_len,
    input  logic [LEN_W-1:0]         hiz_len,
    input  logic [LEN_W-1:0]         acc_len,
    input  logic                     sense_ready,
    input  logic [COLS*WORD_W-1:0]   row_data,
    output logic                     precharge,
    output logic                     bus_hiz,
    output logic                     access_en,
    output logic                     latch_en,
    output logic [$clog2(ROWS)-1:0]  row_sel,
    output logic [WORD_W-1:0]        dout,
    output logic                     dvalid,
    output logic                     done
);
    localparam int COL_W = $clog2(COLS);

    rr_state_e        state;
    rr_ctrl_t         ctrl;
    logic             tmr_load;
    logic             tmr_expired;
    logic [LEN_W-1:0] fsm_len;
    logic [LEN_W-1:0] tmr_len;
    logic [COL_W-1:0] col;

    rr_fsm #(
        .ROWS (ROWS),
        .COLS (COLS),
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sense_ready(sense_ready),
        .pre_len    (pre_len),
        .hiz_len    (hiz_len),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_len    (fsm_len),
        .state      (state),
        .row        (row_sel),
        .col        (col)
    );

    // The access phase length comes straight from the port when entering access.
    assign tmr_len = (state == ST_HIZ) ? acc_len : fsm_len;

    rr_phase_timer #(
        .LEN_W(LEN_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .len    (tmr_len),
        .expired(tmr_expired)
    );

    rr_row_buffer #(
        .COLS  (COLS),
        .WORD_W(WORD_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .capture (ctrl.latch_en),
        .row_in  (row_data),
        .col_idx (col),
        .word_out(dout)
    );

    assign ctrl      = ctrl_of(state);
    assign precharge = ctrl.precharge;
    assign bus_hiz   = ctrl.bus_hiz;
    assign access_en = ctrl.access_en;
    assign latch_en  = ctrl.latch_en;
    assign dvalid    = ctrl.dvalid;
    assign done      = ctrl.done;
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             precharge,
    input logic             bus_hiz,
    input logic             access_en,
    input logic             latch_en,
    input logic [ROW_W-1:0] row_sel,
    input logic             dvalid,
    input logic             done
);
    assert_pre_excl_R9: assert property (@(posedge clk) disable iff (rst)
        precharge |-> (!bus_hiz && !access_en));

    assert_access_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        access_en |-> bus_hiz);

    assert_hiz_after_pre_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_hiz) |-> $past(precharge));

    assert_latch_after_access_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_en) |-> $past(access_en));

    assert_latch_single_R6: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> !latch_en);

    assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (!precharge && !bus_hiz && !access_en));

    assert_row_move_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_sel) |-> ($past(dvalid) || $past(done)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind row_readout_seq rr_checker #(
    .ROW_W($clog2(ROWS))
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .precharge(precharge),
    .bus_hiz  (bus_hiz),
    .access_en(access_en),
    .latch_en (latch_en),
    .row_sel  (row_sel),
    .dvalid   (dvalid),
    .done     (done)
);

// File: tb/row_readout_seq_tb.sv
module row_readout_seq_tb;
    localparam int ROWS   = 4;
    localparam int COLS   = 6;
    localparam int WORD_W = 4;
    localparam int LEN_W  = 3;
    localparam int ROW_W  = $clog2(ROWS);

    localparam int P_IDLE = 0, P_PRE = 1, P_HIZ = 2, P_ACC = 3,
                   P_LAT = 4, P_OUT = 5, P_DONE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LEN_W-1:0] pre_len = '0, hiz_len = '0, acc_len = '0;
    logic sense_ready = 1'b0;
    logic [COLS*WORD_W-1:0] row_data;
    logic [COLS*WORD_W-1:0] noise = '0;
    logic precharge, bus_hiz, access_en, latch_en, dvalid, done;
    logic [ROW_W-1:0] row_sel;
    logic [WORD_W-1:0] dout;

    int total = 0;
    int bad = 0;
    int salt = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int m_ph = P_IDLE, m_cnt = 0, m_row = 0, m_col = 0;

    always #2.5 clk = ~clk;

    row_readout_seq #(
        .ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .LEN_W(LEN_W)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .pre_len(pre_len), .hiz_len(hiz_len), .acc_len(acc_len),
        .sense_ready(sense_ready), .row_data(row_data),
        .precharge(precharge), .bus_hiz(bus_hiz), .access_en(access_en),
        .latch_en(latch_en), .row_sel(row_sel), .dout(dout),
        .dvalid(dvalid), .done(done)
    );

    function automatic logic [WORD_W-1:0] pix(int r, int c, int s);
        return WORD_W'(((r * 5) + (c * 3) + s + (r * c)) ^ (c >> 1));
    endfunction

    function automatic logic [COLS*WORD_W-1:0] row_vec(int r, int s);
        logic [COLS*WORD_W-1:0] v;
        for (int c = 0; c < COLS; c++) v[c*WORD_W +: WORD_W] = pix(r, c, s);
        return v;
    endfunction

    function automatic int eff(logic [LEN_W-1:0] l);
        return (l == '0) ? 1 : int'(l);
    endfunction

    function automatic logic [5:0] exp_ctrl(int ph);
        case (ph)
            P_PRE:  return 6'b100000;
            P_HIZ:  return 6'b010000;
            P_ACC:  return 6'b011000;
            P_LAT:  return 6'b011100;
            P_OUT:  return 6'b000010;
            P_DONE: return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic string tag_of(int ph);
        case (ph)
            P_PRE:  return "R3";
            P_HIZ:  return "R4";
            P_ACC:  return "R5";
            P_LAT:  return "R6";
            P_OUT:  return "R7";
            P_DONE: return "R9";
            default: return "R1/R2";
        endcase
    endfunction

    // Array model: the addressed row is visible only while access is on.
    always_comb row_data = access_en ? row_vec(int'(row_sel), salt) : noise;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cycles);
        end
    endtask

    task automatic step(input bit go, input int sr_mode);
        logic [5:0] got;
        @(negedge clk);
        got = {precharge, bus_hiz, access_en, latch_en, dvalid, done};
        chk(got == exp_ctrl(m_ph), tag_of(m_ph), int'(got), int'(exp_ctrl(m_ph)));
        chk(int'(row_sel) == m_row, "R8", int'(row_sel), m_row);
        if (m_ph == P_OUT)
            chk(dout == pix(m_row, m_col, salt), "R7", int'(dout), int'(pix(m_row, m_col, salt)));
        start = go;
        case (sr_mode)
            0: sense_ready = 1'b1;
            1: sense_ready = ($urandom % 2) == 0;
            default: sense_ready = ($urandom % 4) == 0;
        endcase
        for (int k = 0; k < COLS; k++) noise[k*WORD_W +: WORD_W] = WORD_W'($urandom);
        case (m_ph)
            P_IDLE: if (go) begin m_ph = P_PRE; m_cnt = 1; m_row = 0; end
            P_PRE: if (m_cnt >= eff(pre_len)) begin m_ph = P_HIZ; m_cnt = 1; end else m_cnt++;
            P_HIZ: if (m_cnt >= eff(hiz_len)) begin m_ph = P_ACC; m_cnt = 1; end else m_cnt++;
            P_ACC: if (m_cnt >= eff(acc_len) && sense_ready) m_ph = P_LAT; else m_cnt++;
            P_LAT: begin m_ph = P_OUT; m_col = 0; end
            P_OUT: if (m_col == COLS - 1) begin
                if (m_row == ROWS - 1) m_ph = P_DONE;
                else begin m_row++; m_ph = P_PRE; m_cnt = 1; end
            end else m_col++;
            P_DONE: begin m_ph = P_IDLE; m_row = 0; end
            default: m_ph = P_IDLE;
        endcase
    endtask

    task automatic run_frame(input int pl, input int hl, input int al,
                             input int sr_mode, input bit stray);
        int n = 0;
        pre_len = LEN_W'(pl);
        hiz_len = LEN_W'(hl);
        acc_len = LEN_W'(al);
        salt = int'($urandom % 1000);
        step(1'b1, sr_mode);
        while (m_ph != P_IDLE && n < 2000) begin
            // R2: stray start pulses mid-frame must be ignored
            step(stray && (($urandom % 8) == 0), sr_mode);
            n++;
        end
        chk(n < 2000, "R9", n, 2000);
        step(1'b0, sr_mode);
        step(1'b0, sr_mode);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, and idle stays quiet without start
        chk({precharge, bus_hiz, access_en, latch_en, dvalid, done} == 6'b0, "R1",
            int'({precharge, bus_hiz, access_en, latch_en, dvalid, done}), 0);
        chk(row_sel == '0, "R1", int'(row_sel), 0);
        repeat (3) step(1'b0, 1);
        // R3/R4/R5: zero lengths count as one cycle, sense always ready
        run_frame(0, 0, 0, 0, 1'b0);
        // maximum lengths, random sense ready
        run_frame(7, 7, 7, 1, 1'b0);
        // mixed short/long, sparse sense ready, stray starts (R2)
        run_frame(1, 7, 0, 2, 1'b1);
        run_frame(7, 0, 1, 2, 1'b1);
        for (int f = 0; f < 8; f++)
            run_frame(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                      int'($urandom % 3), (f % 2) == 1);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule